// File: doc/BRIEF.md
# Bus Acknowledge Responder with Programmable Wait States

This block drives the active-low data-transfer-acknowledge line of an asynchronous microprocessor bus. It watches the address strobe and the two byte-lane data strobes, decides when a transfer is under way, and returns the acknowledge after a wait count chosen by the addressed region. A region with a count of zero is acknowledged on the same clock edge that first sees the access, which lets a cycle finish without any wait states.

The acknowledge is withheld for as long as a DMA hold request is high. The processor waits without limit while the acknowledge is absent, so this is how a DMA engine stalls it. The acknowledge is removed one system clock after the access condition goes away. It is also forced off whenever the processor reports the first bus state of a cycle. A later cycle can therefore never see an acknowledge that belongs to an earlier one.

Top module: `bus_ack_responder`

## Requirements
- R1: An access is present only when `as_ni` is low and at least one of `uds_ni` or `lds_ni` is low. The address strobe alone, or a data strobe alone, never produces an acknowledge.
- R2: Region r takes its wait count W (0 to 7) from `waits_i[r*3+2:r*3]`. `dtack_no` goes low on the W-th clock edge after the edge that first samples the access. With W = 0 it goes low on that first edge.
- R3: The region is captured on the edge that first samples the access. Changes on `region_i` or `waits_i` after that edge do not alter the timing of the current cycle.
- R4: `dtack_no` returns high on the first clock edge that samples the access condition as false.
- R5: On every edge that samples `dma_hold_i` high, `dtack_no` is driven high.
- R6: Suppose the hold arrives in the middle of a cycle. Then `dtack_no` goes low on the first edge at which the hold is low and the wait count has expired.
- R7: On every edge that samples `bus_state_i` equal to 0 (state S0), `dtack_no` is driven high. Codes 1 to 7 stand for states S1 to S7.
- R8: While `rst_ni` is low, `dtack_no` is high.
- R9: Once low, `dtack_no` stays low for as long as the access lasts, the hold is low and the bus state is not S0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_ni | input | 1 | Address strobe, active low |
| uds_ni | input | 1 | Upper byte data strobe, active low |
| lds_ni | input | 1 | Lower byte data strobe, active low |
| region_i | input | $clog2(NUM_REGIONS) | Region selected by the address decoder |
| waits_i | input | NUM_REGIONS*WAIT_W | Wait count of each region, 3 bits per region |
| dma_hold_i | input | 1 | DMA hold request, active high |
| bus_state_i | input | 3 | Current processor bus state, 0 = S0 |
| dtack_no | output | 1 | Data transfer acknowledge, active low |

## Verification
The acknowledge passes through a single register. An input change applied at one edge is therefore visible after that edge, and an access with wait count W shows the acknowledge W edges after the edge that first samples it. The bench drives its inputs on falling edges and samples on the falling edge that follows the edge it is checking. For a count of W it expects the line high for exactly W samples and low on sample W+1. Release, hold and S0 effects are each expected on the very next sample.

// File: rtl/bus_ack_pkg.sv
`timescale 1ns/1ps
package bus_ack_pkg;
  typedef logic [2:0] bus_state_t;
  localparam bus_state_t ST_CYCLE_START = 3'd0;
endpackage

// File: rtl/ack_access_detect.sv
`timescale 1ns/1ps
module ack_access_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_ni,
  input  logic uds_ni,
  input  logic lds_ni,
  output logic access_o,
  output logic start_o
);
  logic prev_q;

  assign access_o = ~as_ni & (~uds_ni | ~lds_ni);
  assign start_o  = access_o & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= access_o;
  end
endmodule

// File: rtl/ack_wait_counter.sv
`timescale 1ns/1ps
module ack_wait_counter #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 3,
  localparam int REG_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          access_i,
  input  logic                          start_i,
  input  logic [REG_W-1:0]              region_i,
  input  logic [NUM_REGIONS*WAIT_W-1:0] waits_i,
  output logic                          expired_o
);
  logic [WAIT_W-1:0] wait_tab [NUM_REGIONS];
  logic [WAIT_W-1:0] cnt_q, remaining;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_tab
    assign wait_tab[g] = waits_i[g*WAIT_W +: WAIT_W];
  end

  // region latched at the detecting edge; counter carries it afterwards
  assign remaining = start_i ? wait_tab[region_i] : cnt_q;
  assign expired_o = (remaining == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!access_i)  cnt_q <= '0;
    else if (!expired_o) cnt_q <= remaining - 1'b1;
    else                 cnt_q <= '0;
  end
endmodule

// File: rtl/ack_output_reg.sv
`timescale 1ns/1ps
module ack_output_reg
  import bus_ack_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       access_i,
  input  logic       expired_i,
  input  logic       hold_i,
  input  bus_state_t bus_state_i,
  output logic       dtack_no
);
  logic ack_d;

  assign ack_d = access_i & expired_i & ~hold_i & (bus_state_i != ST_CYCLE_START);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dtack_no <= 1'b1;
    else         dtack_no <= ~ack_d;
  end
endmodule

// File: rtl/bus_ack_responder.sv
`timescale 1ns/1ps
module bus_ack_responder #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 3,
  localparam int REG_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          as_ni,
  input  logic                          uds_ni,
  input  logic                          lds_ni,
  input  logic [REG_W-1:0]              region_i,
  input  logic [NUM_REGIONS*WAIT_W-1:0] waits_i,
  input  logic                          dma_hold_i,
  input  logic [2:0]                    bus_state_i,
  output logic                          dtack_no
);
  logic access_w, start_w, expired_w;

  ack_access_detect u_det (
    .clk_i, .rst_ni, .as_ni, .uds_ni, .lds_ni,
    .access_o(access_w), .start_o(start_w)
  );

  ack_wait_counter #(.NUM_REGIONS(NUM_REGIONS), .WAIT_W(WAIT_W)) u_cnt (
    .clk_i, .rst_ni, .access_i(access_w), .start_i(start_w),
    .region_i, .waits_i, .expired_o(expired_w)
  );

  ack_output_reg u_out (
    .clk_i, .rst_ni, .access_i(access_w), .expired_i(expired_w),
    .hold_i(dma_hold_i), .bus_state_i, .dtack_no
  );
endmodule

// File: rtl/bus_ack_responder_chk.sv
`timescale 1ns/1ps
module bus_ack_responder_chk #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 3,
  localparam int REG_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          as_ni,
  input logic                          uds_ni,
  input logic                          lds_ni,
  input logic [REG_W-1:0]              region_i,
  input logic [NUM_REGIONS*WAIT_W-1:0] waits_i,
  input logic                          dma_hold_i,
  input logic [2:0]                    bus_state_i,
  input logic                          dtack_no,
  input logic                          access_w,
  input logic                          start_w
);
  logic pin_access;
  assign pin_access = ~as_ni & (~uds_ni | ~lds_ni);

  assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_access |=> dtack_no);

  assert_dma_block_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_hold_i |=> dtack_no);

  assert_s0_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_state_i == 3'd0) |=> dtack_no);

  assert_zero_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_w && waits_i[region_i*WAIT_W +: WAIT_W] == '0 && !dma_hold_i
     && bus_state_i != 3'd0) |=> !dtack_no);

  assert_hold_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && access_w && !dma_hold_i && bus_state_i != 3'd0) |=> !dtack_no);

  assert_decode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_ni || (uds_ni && lds_ni)) |=> dtack_no);
endmodule

bind bus_ack_responder bus_ack_responder_chk #(
  .NUM_REGIONS(NUM_REGIONS), .WAIT_W(WAIT_W)
) u_chk (.*);

// File: tb/sim_bus_ack_responder.sv
`timescale 1ns/1ps
module sim_bus_ack_responder;
  localparam int NR = 4;
  localparam int WW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          as_ni = 1'b1, uds_ni = 1'b1, lds_ni = 1'b1;
  logic [1:0]    region_i = '0;
  logic [NR*WW-1:0] waits_i = '0;
  logic          dma_hold_i = 1'b0;
  logic [2:0]    bus_state_i = 3'd0;
  logic          dtack_no;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bus_ack_responder #(.NUM_REGIONS(NR), .WAIT_W(WW)) u0 (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit act, input bit exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dtack_no actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic idle();
    as_ni = 1'b1; uds_ni = 1'b1; lds_ni = 1'b1; bus_state_i = 3'd0;
    step();
  endtask

  // sets region r to w, every other region to 7-w
  task automatic set_waits(input int r, input int w);
    for (int i = 0; i < NR; i++)
      waits_i[i*WW +: WW] = (i == r) ? w[2:0] : 3'(7 - w);
  endtask

  task automatic run_cycle(input int r, input int w, input int lanes);
    set_waits(r, w);
    region_i = r[1:0];
    bus_state_i = 3'd2;
    as_ni = 1'b0;
    uds_ni = (lanes == 1);
    lds_ni = (lanes == 0);
    for (int k = 1; k <= w + 2; k++) begin
      step();
      chk(dtack_no, (k <= w), (k <= w) ? "R2 wait" : ((k == w + 1) ? "R2 ack" : "R9 stay"));
    end
    as_ni = 1'b1; uds_ni = 1'b1; lds_ni = 1'b1;
    step();
    chk(dtack_no, 1'b1, "R4 release");
    idle();
  endtask

  initial begin
    step();
    chk(dtack_no, 1'b1, "R8 reset");
    as_ni = 1'b0; uds_ni = 1'b0; bus_state_i = 3'd2;
    step();
    chk(dtack_no, 1'b1, "R8 reset with access");
    as_ni = 1'b1; uds_ni = 1'b1; bus_state_i = 3'd0;
    rst_ni = 1'b1;
    step();

    // R2 sweep: all regions, all wait counts, all lane combinations
    for (int r = 0; r < NR; r++)
      for (int w = 0; w < 8; w++)
        run_cycle(r, w, (r + w) % 3);

    // R1: address strobe alone, data strobes alone
    set_waits(0, 0); region_i = 2'd0; bus_state_i = 3'd2;
    as_ni = 1'b0;
    for (int k = 0; k < 4; k++) begin step(); chk(dtack_no, 1'b1, "R1 as only"); end
    as_ni = 1'b1; uds_ni = 1'b0; lds_ni = 1'b0;
    for (int k = 0; k < 4; k++) begin step(); chk(dtack_no, 1'b1, "R1 ds only"); end
    idle();

    // R3: region switched after detection
    waits_i = '0; waits_i[0 +: WW] = 3'd4;
    region_i = 2'd0; bus_state_i = 3'd2; as_ni = 1'b0; lds_ni = 1'b0;
    step(); chk(dtack_no, 1'b1, "R3 wait");
    region_i = 2'd1; waits_i[0 +: WW] = 3'd0;
    for (int k = 2; k <= 5; k++) begin
      step(); chk(dtack_no, (k <= 4), "R3 latched region");
    end
    idle();

    // R5: hold before access, then hold raised after acknowledge
    waits_i = '0; region_i = 2'd2; dma_hold_i = 1'b1;
    bus_state_i = 3'd2; as_ni = 1'b0; uds_ni = 1'b0;
    for (int k = 0; k < 6; k++) begin step(); chk(dtack_no, 1'b1, "R5 hold"); end
    dma_hold_i = 1'b0;
    step(); chk(dtack_no, 1'b0, "R6 release hold expired");
    dma_hold_i = 1'b1;
    step(); chk(dtack_no, 1'b1, "R5 hold after ack");
    dma_hold_i = 1'b0;
    step(); chk(dtack_no, 1'b0, "R6 reack");
    idle();

    // R6: hold arrives mid-count, released after expiry
    set_waits(3, 3); region_i = 2'd3; bus_state_i = 3'd2;
    as_ni = 1'b0; uds_ni = 1'b0; lds_ni = 1'b0;
    step(); chk(dtack_no, 1'b1, "R6 count");
    dma_hold_i = 1'b1;
    for (int k = 2; k <= 6; k++) begin step(); chk(dtack_no, 1'b1, "R6 held"); end
    dma_hold_i = 1'b0;
    step(); chk(dtack_no, 1'b0, "R6 after hold");
    idle();

    // R6: hold released before count expires
    set_waits(1, 6); region_i = 2'd1; bus_state_i = 3'd2;
    as_ni = 1'b0; lds_ni = 1'b0; dma_hold_i = 1'b1;
    for (int k = 1; k <= 2; k++) begin step(); chk(dtack_no, 1'b1, "R6 early hold"); end
    dma_hold_i = 1'b0;
    for (int k = 3; k <= 7; k++) begin
      step(); chk(dtack_no, (k <= 6), "R6 count continues");
    end
    idle();

    // R7: S0 forces release while access continues
    waits_i = '0; region_i = 2'd0; bus_state_i = 3'd3; as_ni = 1'b0; uds_ni = 1'b0;
    step(); chk(dtack_no, 1'b0, "R7 pre ack");
    bus_state_i = 3'd0;
    step(); chk(dtack_no, 1'b1, "R7 s0");
    bus_state_i = 3'd1;
    step(); chk(dtack_no, 1'b0, "R7 after s0");
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule